// File: doc/BRIEF.md
# LCD Raster Timing Generator

This block produces the scan timing for a parallel RGB panel. From five packed 32-bit configuration words it generates horizontal sync, vertical sync, a data-enable strobe and the current pixel column and row. Each word holds one parameter for both axes: the horizontal value in the low half and the vertical value in the high half.

Both axes step through the same five phases in a fixed order. The horizontal axis counts pixel-clock enables. The vertical axis counts completed lines. A phase programmed to zero length is skipped. The configuration is held in a shadow copy that is refreshed only when a frame wraps, so a frame is never scanned with mixed settings. A per-sync polarity control selects active-low sync outputs. Until the first pixel-clock enable after reset, all outputs stay low. That first enable loads the configuration and begins the raster at column zero of line zero.

Top module: `lcd_raster_gen`

## Requirements
- R1: Every configuration word holds the horizontal value in bits 15:0 and the vertical value in bits 31:16. The size word holds the active width in its low half and the active height in its high half.
- R2: A line runs through the phases lead-in (reference-to-sync), sync, back porch, active and front porch, in that order. Each phase lasts its programmed number of enabled pixel clocks, so a line is the sum of the five horizontal lengths.
- R3: The vertical axis follows the same phase order, counted in whole lines. A frame is the sum of the five vertical lengths, in lines.
- R4: The sync pulse begins exactly lead-in periods after the line (or frame) start. A lead-in of 1 with the front porch reduced by 1 gives the same line and frame length as a lead-in of 0.
- R5: de_o is high only when both axes are in their active phase. x_o and y_o give the offset inside the active area and read zero elsewhere.
- R6: A phase of length zero is skipped with no extra cycle. With no lead-in, sync starts on the first pixel of the line.
- R7: With its invert bit at 0 a sync output is high during its sync phase. With the invert bit at 1 it is low during its sync phase and high otherwise.
- R8: Changes to the configuration words and invert bits take effect only at the next frame start. A change in mid-frame leaves the rest of that frame unchanged.
- R9: After reset, and until the first enabled pixel clock, every output is low. The first enabled clock starts the raster at line 0, pixel 0.
- R10: While pix_en_i is low, no output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_en_i | input | 1 | Pixel-clock enable; advances the raster by one pixel |
| lead_i | input | 32 | Lead-in length before sync (vertical:horizontal) |
| sync_len_i | input | 32 | Sync pulse length (vertical:horizontal) |
| back_len_i | input | 32 | Back porch length (vertical:horizontal) |
| front_len_i | input | 32 | Front porch length (vertical:horizontal) |
| size_i | input | 32 | Active height:width |
| hs_inv_i | input | 1 | Invert horizontal sync polarity |
| vs_inv_i | input | 1 | Invert vertical sync polarity |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data enable |
| x_o | output | $clog2(MAX_W) | Active column |
| y_o | output | $clog2(MAX_H) | Active row |

## Verification
The hardest case to reach from the ports is a configuration change that arrives in mid-frame. It must stay invisible until the vertical and horizontal counters wrap together. The stimulus reprograms every word partway through a long frame, then counts data-enable pixels over that frame and over the next one. A cycle-by-cycle position model computes each phase from cumulative sums rather than a phase sequencer. The model follows both frames and checks every output. Zero-length phases and a slowed pixel-enable cadence are covered by rows of the vector table.

// File: rtl/lcd_raster_pkg.sv
package lcd_raster_pkg;
  localparam int FIELD_W = 16;
  localparam int NPH     = 5;

  // order is behaviour: the scan visits phases in ascending value
  typedef enum logic [2:0] {
    PH_LEAD  = 3'd0,
    PH_SYNC  = 3'd1,
    PH_BACK  = 3'd2,
    PH_ACT   = 3'd3,
    PH_FRONT = 3'd4
  } phase_e;

  typedef logic [FIELD_W-1:0]          len_t;
  typedef logic [NPH-1:0][FIELD_W-1:0] axis_len_t;
endpackage

// File: rtl/lcd_cfg_shadow.sv
module lcd_cfg_shadow
  import lcd_raster_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      load_i,
  input  logic [31:0] lead_i,
  input  logic [31:0] sync_len_i,
  input  logic [31:0] back_len_i,
  input  logic [31:0] front_len_i,
  input  logic [31:0] size_i,
  input  logic      hs_inv_i,
  input  logic      vs_inv_i,
  output axis_len_t raw_h_o,
  output axis_len_t raw_v_o,
  output axis_len_t cur_h_o,
  output axis_len_t cur_v_o,
  output logic      hs_inv_o,
  output logic      vs_inv_o
);
  localparam int HI = 2 * FIELD_W - 1;

  always_comb begin
    raw_h_o[PH_LEAD]  = lead_i[FIELD_W-1:0];
    raw_h_o[PH_SYNC]  = sync_len_i[FIELD_W-1:0];
    raw_h_o[PH_BACK]  = back_len_i[FIELD_W-1:0];
    raw_h_o[PH_ACT]   = size_i[FIELD_W-1:0];
    raw_h_o[PH_FRONT] = front_len_i[FIELD_W-1:0];
    raw_v_o[PH_LEAD]  = lead_i[HI:FIELD_W];
    raw_v_o[PH_SYNC]  = sync_len_i[HI:FIELD_W];
    raw_v_o[PH_BACK]  = back_len_i[HI:FIELD_W];
    raw_v_o[PH_ACT]   = size_i[HI:FIELD_W];
    raw_v_o[PH_FRONT] = front_len_i[HI:FIELD_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_h_o  <= '0;
      cur_v_o  <= '0;
      hs_inv_o <= 1'b0;
      vs_inv_o <= 1'b0;
    end else if (load_i) begin
      cur_h_o  <= raw_h_o;
      cur_v_o  <= raw_v_o;
      hs_inv_o <= hs_inv_i;
      vs_inv_o <= vs_inv_i;
    end
  end
endmodule

// File: rtl/lcd_axis_seq.sv
module lcd_axis_seq
  import lcd_raster_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      restart_i,
  input  logic      step_i,
  input  axis_len_t cur_len_i,
  input  axis_len_t start_len_i,
  output phase_e    phase_o,
  output len_t      cnt_o,
  output logic      end_o
);
  phase_e phase_q, nxt_ph, st_ph;
  len_t   cnt_q;
  logic   nxt_found, st_found, last_cnt;

  // next non-empty phase after the current one, and first non-empty from the top
  always_comb begin
    nxt_found = 1'b0;
    nxt_ph    = phase_q;
    st_found  = 1'b0;
    st_ph     = PH_ACT;
    for (int i = 0; i < NPH; i++) begin
      if (!nxt_found && i > int'(phase_q) && cur_len_i[i] != '0) begin
        nxt_found = 1'b1;
        nxt_ph    = phase_e'(3'(i));
      end
      if (!st_found && start_len_i[i] != '0) begin
        st_found = 1'b1;
        st_ph    = phase_e'(3'(i));
      end
    end
  end

  assign last_cnt = (cnt_q == cur_len_i[phase_q] - 1'b1);
  assign end_o    = last_cnt && !nxt_found;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_LEAD;
      cnt_q   <= '0;
    end else if (restart_i || (step_i && end_o)) begin
      phase_q <= st_ph;
      cnt_q   <= '0;
    end else if (step_i && last_cnt) begin
      phase_q <= nxt_ph;
      cnt_q   <= '0;
    end else if (step_i) begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  assign phase_o = phase_q;
  assign cnt_o   = cnt_q;

  assert_step_order_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && last_cnt && !end_o && !restart_i) |=> (phase_q > $past(phase_q)));

  assert_skip_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && last_cnt && !end_o && !restart_i) |=> (cur_len_i[phase_q] != '0));

  assert_cnt_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_len_i[phase_q] != '0) |-> (cnt_q < cur_len_i[phase_q]));
endmodule

// File: rtl/lcd_raster_gen.sv
module lcd_raster_gen
  import lcd_raster_pkg::*;
#(
  parameter int MAX_W = 1366,
  parameter int MAX_H = 768
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     pix_en_i,
  input  logic [31:0]              lead_i,
  input  logic [31:0]              sync_len_i,
  input  logic [31:0]              back_len_i,
  input  logic [31:0]              front_len_i,
  input  logic [31:0]              size_i,
  input  logic                     hs_inv_i,
  input  logic                     vs_inv_i,
  output logic                     hsync_o,
  output logic                     vsync_o,
  output logic                     de_o,
  output logic [$clog2(MAX_W)-1:0] x_o,
  output logic [$clog2(MAX_H)-1:0] y_o
);
  localparam int XW = $clog2(MAX_W);
  localparam int YW = $clog2(MAX_H);

  axis_len_t raw_h, raw_v, cur_h, cur_v, start_h, start_v;
  logic      hs_inv, vs_inv;
  logic      loaded_q, start, h_step, h_wrap, frame_end, use_raw, cfg_load;
  logic      h_end, v_end;
  phase_e    h_ph, v_ph;
  len_t      h_cnt, v_cnt;

  assign start     = pix_en_i && !loaded_q;
  assign h_step    = pix_en_i && loaded_q;
  assign h_wrap    = h_step && h_end;
  assign frame_end = h_wrap && v_end;
  assign use_raw   = !loaded_q || frame_end;
  assign cfg_load  = start || frame_end;
  assign start_h   = use_raw ? raw_h : cur_h;
  assign start_v   = use_raw ? raw_v : cur_v;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    loaded_q <= 1'b0;
    else if (start) loaded_q <= 1'b1;
  end

  lcd_cfg_shadow i_shadow (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (cfg_load),
    .lead_i      (lead_i),
    .sync_len_i  (sync_len_i),
    .back_len_i  (back_len_i),
    .front_len_i (front_len_i),
    .size_i      (size_i),
    .hs_inv_i    (hs_inv_i),
    .vs_inv_i    (vs_inv_i),
    .raw_h_o     (raw_h),
    .raw_v_o     (raw_v),
    .cur_h_o     (cur_h),
    .cur_v_o     (cur_v),
    .hs_inv_o    (hs_inv),
    .vs_inv_o    (vs_inv)
  );

  lcd_axis_seq i_h_axis (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .restart_i   (start),
    .step_i      (h_step),
    .cur_len_i   (cur_h),
    .start_len_i (start_h),
    .phase_o     (h_ph),
    .cnt_o       (h_cnt),
    .end_o       (h_end)
  );

  lcd_axis_seq i_v_axis (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .restart_i   (start),
    .step_i      (h_wrap),
    .cur_len_i   (cur_v),
    .start_len_i (start_v),
    .phase_o     (v_ph),
    .cnt_o       (v_cnt),
    .end_o       (v_end)
  );

  always_comb begin
    hsync_o = loaded_q && ((h_ph == PH_SYNC) ^ hs_inv);
    vsync_o = loaded_q && ((v_ph == PH_SYNC) ^ vs_inv);
    de_o    = loaded_q && (h_ph == PH_ACT) && (v_ph == PH_ACT);
    x_o     = (loaded_q && h_ph == PH_ACT) ? h_cnt[XW-1:0] : '0;
    y_o     = (loaded_q && v_ph == PH_ACT) ? v_cnt[YW-1:0] : '0;
  end

  assert_freeze_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_en_i |=> ($stable(hsync_o) && $stable(vsync_o) && $stable(de_o)
                   && $stable(x_o) && $stable(y_o)));

  assert_de_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    de_o |-> (XW'(x_o) < cur_h[PH_ACT] && YW'(y_o) < cur_v[PH_ACT]));

  assert_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !loaded_q |-> !(hsync_o || vsync_o || de_o));

  assert_sync_no_de_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loaded_q && (hsync_o ^ hs_inv)) |-> !de_o);
endmodule

// File: tb/test_lcd_raster_gen.sv
`timescale 1ns/1ps
module test_lcd_raster_gen;
  localparam int MAX_W = 1366;
  localparam int MAX_H = 768;
  localparam int XW = $clog2(MAX_W);
  localparam int YW = $clog2(MAX_H);
  localparam int NV = 4;

  typedef struct packed {
    logic [31:0] lead, sync, back, front, size;
    logic [1:0]  inv;   // {vs, hs}
    logic [7:0]  div;   // enable every div-th clock
    logic [15:0] ht, vt;
  } vec_t;

  // rows: words (V in 31:16, H in 15:0), inversion, enable cadence, expected line/frame length
  localparam vec_t VECS [NV] = '{
    '{32'h0001_0001, 32'h0001_0002, 32'h0002_0003, 32'h0001_0002, 32'h0004_0008, 2'b00, 8'd1, 16'd16, 16'd9},
    '{32'h0000_0000, 32'h0001_0002, 32'h0002_0003, 32'h0002_0003, 32'h0004_0008, 2'b11, 8'd2, 16'd16, 16'd9},
    '{32'h0000_0000, 32'h0001_0001, 32'h0000_0000, 32'h0000_0000, 32'h0003_0005, 2'b01, 8'd1, 16'd6,  16'd4},
    '{32'h0001_0001, 32'h0002_0004, 32'h0003_0006, 32'h0002_0005, 32'h0006_0014, 2'b10, 8'd3, 16'd36, 16'd14}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b1;
  logic pix_en = 1'b0;
  logic [31:0] lead_w, sync_w, back_w, front_w, size_w;
  logic hs_inv, vs_inv;
  logic hsync, vsync, de;
  logic [XW-1:0] x;
  logic [YW-1:0] y;

  always #2.5 clk = ~clk;

  lcd_raster_gen #(.MAX_W(MAX_W), .MAX_H(MAX_H)) i_lcd_raster_gen (
    .clk_i(clk), .rst_ni(rst_ni), .pix_en_i(pix_en),
    .lead_i(lead_w), .sync_len_i(sync_w), .back_len_i(back_w),
    .front_len_i(front_w), .size_i(size_w),
    .hs_inv_i(hs_inv), .vs_inv_i(vs_inv),
    .hsync_o(hsync), .vsync_o(vsync), .de_o(de), .x_o(x), .y_o(y)
  );

  int checks = 0, errors = 0;

  // position model
  bit m_on, m_fs;
  int m_h, m_v, m_ht, m_vt;
  int mh[5], mv[5];
  bit m_hinv, m_vinv;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    lead_w = v.lead; sync_w = v.sync; back_w = v.back; front_w = v.front; size_w = v.size;
    hs_inv = v.inv[0]; vs_inv = v.inv[1];
  endtask

  // R1: low half horizontal, high half vertical; index 3 is the active size
  task automatic model_load();
    mh[0] = lead_w[15:0];  mv[0] = lead_w[31:16];
    mh[1] = sync_w[15:0];  mv[1] = sync_w[31:16];
    mh[2] = back_w[15:0];  mv[2] = back_w[31:16];
    mh[3] = size_w[15:0];  mv[3] = size_w[31:16];
    mh[4] = front_w[15:0]; mv[4] = front_w[31:16];
    m_ht = mh[0] + mh[1] + mh[2] + mh[3] + mh[4];
    m_vt = mv[0] + mv[1] + mv[2] + mv[3] + mv[4];
    m_hinv = hs_inv; m_vinv = vs_inv;
  endtask

  task automatic model_step();
    m_fs = 1'b0;
    if (!m_on) begin
      m_on = 1'b1; model_load(); m_h = 0; m_v = 0; m_fs = 1'b1;
    end else begin
      m_h++;
      if (m_h == m_ht) begin
        m_h = 0; m_v++;
        if (m_v == m_vt) begin m_v = 0; model_load(); m_fs = 1'b1; end
      end
    end
  endtask

  function automatic int phase_of(input int p, input int l[5]);
    int acc = 0;
    for (int i = 0; i < 4; i++) begin
      acc += l[i];
      if (p < acc) return i;
    end
    return 4;
  endfunction

  task automatic compare();
    int hp, vp, ex, ey;
    bit ehs, evs, ede;
    if (!m_on) begin
      ehs = 0; evs = 0; ede = 0; ex = 0; ey = 0;
    end else begin
      hp = phase_of(m_h, mh); vp = phase_of(m_v, mv);
      ehs = (hp == 1) ^ m_hinv;
      evs = (vp == 1) ^ m_vinv;
      ede = (hp == 3) && (vp == 3);
      ex = (hp == 3) ? m_h - (mh[0] + mh[1] + mh[2]) : 0;
      ey = (vp == 3) ? m_v - (mv[0] + mv[1] + mv[2]) : 0;
    end
    chk(hsync == ehs, "R2 R7", "hsync", int'(hsync), int'(ehs));
    chk(vsync == evs, "R3 R7", "vsync", int'(vsync), int'(evs));
    chk(de == ede, "R5", "de", int'(de), int'(ede));
    chk(int'(x) == ex, "R5 R1", "x", int'(x), ex);
    chk(int'(y) == ey, "R5 R1", "y", int'(y), ey);
  endtask

  task automatic tick(input bit en);
    pix_en = en;
    @(posedge clk);
    if (en && rst_ni) model_step();
    @(negedge clk);
    compare();
  endtask

  // waits for the next frame start, then runs one full frame at cadence div
  task automatic run_frame(input int div, input int change_at, input vec_t nv,
                           output int de_cnt, output int hs_cnt,
                           output int first_rise, output int period);
    int ph = 0, n = 0, r1 = -1, r2 = -1;
    bit prev, act, en;
    do begin
      en = (ph % div) == 0; ph++;
      tick(en);
    end while (!(en && m_fs));
    de_cnt = 0; hs_cnt = 0;
    prev = 1'b0;
    while (1) begin
      act = hsync ^ m_hinv;
      if (de) de_cnt++;
      if (act) hs_cnt++;
      if (act && !prev) begin
        if (r1 < 0) r1 = n; else if (r2 < 0) r2 = n;
      end
      prev = act;
      n++;
      if (n == m_ht * m_vt) break;
      if (n == change_at) apply(nv);
      do begin
        en = (ph % div) == 0; ph++;
        tick(en);
      end while (!en);
    end
    first_rise = r1;
    period = r2 - r1;
  endtask

  initial begin
    #(200000 * 5);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int dc, hc, fr, pd;
    logic [4+XW+YW-1:0] snap;
    apply(VECS[0]);
    hs_inv = 1'b1; vs_inv = 1'b1;
    #1 rst_ni = 1'b0;
    repeat (3) tick(1'b0);
    @(negedge clk) rst_ni = 1'b1;
    // R9: idle before any enable, even with inversion requested
    repeat (3) tick(1'b0);
    chk(hsync == 1'b0 && vsync == 1'b0, "R9", "idle syncs", int'({hsync, vsync}), 0);
    apply(VECS[0]);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i]);
      run_frame(int'(VECS[i].div), -1, VECS[i], dc, hc, fr, pd);
      chk(dc == int'(VECS[i].size[15:0]) * int'(VECS[i].size[31:16]), "R5", "de pixels per frame",
          dc, int'(VECS[i].size[15:0]) * int'(VECS[i].size[31:16]));
      chk(hc == int'(VECS[i].sync[15:0]) * int'(VECS[i].vt), "R2", "hsync pixels per frame",
          hc, int'(VECS[i].sync[15:0]) * int'(VECS[i].vt));
      chk(pd == int'(VECS[i].ht), "R4", "line period", pd, int'(VECS[i].ht));
      chk(fr == int'(VECS[i].lead[15:0]), "R4 R6", "sync start offset", fr, int'(VECS[i].lead[15:0]));
      chk(m_ht * m_vt == int'(VECS[i].ht) * int'(VECS[i].vt), "R3", "frame length",
          m_ht * m_vt, int'(VECS[i].ht) * int'(VECS[i].vt));
    end

    // R10: outputs hold while enable is low
    repeat (5) tick(1'b1);
    snap = {hsync, vsync, de, 1'b0, x, y};
    for (int k = 0; k < 8; k++) begin
      tick(1'b0);
      chk({hsync, vsync, de, 1'b0, x, y} == snap, "R10", "frozen outputs",
          int'({hsync, vsync, de, 1'b0, x, y}), int'(snap));
    end

    // R8: reprogram mid-frame; current frame keeps old size, next uses new
    apply(VECS[3]);
    run_frame(1, 200, VECS[0], dc, hc, fr, pd);
    chk(dc == 120, "R8", "de pixels in changed frame", dc, 120);
    run_frame(1, -1, VECS[0], dc, hc, fr, pd);
    chk(dc == 32, "R8", "de pixels after boundary", dc, 32);
    chk(pd == 16, "R8", "line period after boundary", pd, 16);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule